// File: doc/BRIEF.md
# Right-Channel Audio Capture with Noise Gate and Level Bar

This block sits behind an audio converter that sends data in the left-justified serial format. It watches three lines: the bit clock, the frame (channel-select) clock and the serial data line. It runs on the chip's own system clock, and each input passes through a two-stage synchronizer. Only the right-channel half of each frame is collected. The block assembles that half into a 16-bit two's-complement word, most significant bit first.

Each finished word passes through a dead-zone gate that works on the absolute value. Idle noise a few counts either side of zero comes out as an exact zero. Without the gate, a small negative value would show up as a word of nearly all ones. The gated word is presented on a sample output with a one-cycle strobe. It is also shown on a 16-segment bar, where the lit segments grow from the bottom with the signal's magnitude. The bar can drive a row of indicator lamps as a sound-level meter.

Top module: `audio_level_meter`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, `sample_o`, `bar_o` and `sample_vld_o` all become zero.
- R2: A frame clock high level marks the right channel. The first rising bit-clock edge after the frame clock goes high carries bit 15 of the word. The next 15 rising edges carry bits 14 down to 0.
- R3: Bits sent while the frame clock is low (the left channel) never change `sample_o` or `bar_o` and never raise `sample_vld_o`.
- R4: The outputs update only after all 16 right-channel bits have arrived. `sample_vld_o` is then high for exactly one `clk` cycle. A right half that ends with fewer than 16 bits leaves the outputs unchanged and raises no strobe.
- R5: Bits after the 16th within the same right half are ignored.
- R6: Let the magnitude be the absolute value of the captured word. If the magnitude is below `GATE_LEVEL` (default 8), `sample_o` is zero. Otherwise `sample_o` equals the captured word unchanged.
- R7: The absolute value of -32768 (0x8000) saturates to 32767. Such a word passes the gate and lights the whole bar.
- R8: `bar_o` is a thermometer code built from the gated magnitude m. Bit 0 is lit when m is nonzero, and bit k (k from 1 to 15) is lit when m is at least 2^(k-1). A zero sample therefore gives an empty bar.
- R9: Between strobes, `sample_o` and `bar_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock from the converter |
| lrclk_i | input | 1 | Frame clock, high for the right channel |
| sdata_i | input | 1 | Serial audio data, MSB first |
| sample_o | output | 16 | Gated right-channel sample, two's complement |
| bar_o | output | 16 | Thermometer-coded level bar, bit 0 at the bottom |
| sample_vld_o | output | 1 | One-cycle strobe when a new sample is presented |

## Verification
The assertions check four properties on every cycle. The strobe never lasts more than one cycle. The outputs hold still between strobes. The bar is always a contiguous run from bit 0 and is empty exactly when the sample is zero. Any nonzero sample has a magnitude at or above the gate level. Other behaviours can only be shown by the bench's scenarios. These are the bit order and channel selection, left-channel words being dropped, truncated and overlong right halves, the saturation at -32768, and the exact bar length for each magnitude.

// File: rtl/alm_pkg.sv
// Package: shared widths and types for the audio level meter.
// Assumes the sample width equals the number of bar segments.
package alm_pkg;
    localparam int SAMPLE_W = 16;
    typedef logic [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/alm_serial_rx.sv
// Module: alm_serial_rx
// Recovers the right-channel word from a left-justified serial stream.
// Assumes clk runs at least 8x faster than the bit clock. All three
// serial lines pass through the same synchronizer depth, so their
// relative timing is kept.
module alm_serial_rx #(
    parameter int  W         = alm_pkg::SAMPLE_W,
    parameter int  SYNC_N    = 2,
    parameter logic RIGHT_LVL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bclk_i,
    input  logic         lrclk_i,
    input  logic         sdata_i,
    output logic [W-1:0] word_o,
    output logic         word_vld_o
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(W);
    localparam logic [CW-1:0] CNT_LAST = CW'(W - 1);

    logic [SYNC_N-1:0] bclk_sy, lr_sy, sd_sy;
    logic              bclk_d;
    logic              lr_prev;
    logic [CW-1:0]     cnt;
    logic [W-1:0]      shreg;
    logic              done;
    logic              bclk_s, lr_s, sd_s, bclk_rise;

    // Purpose: synchronize the three serial lines into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_sy <= '0;
            lr_sy   <= {SYNC_N{RIGHT_LVL}};
            sd_sy   <= '0;
        end else begin
            bclk_sy <= {bclk_sy[SYNC_N-2:0], bclk_i};
            lr_sy   <= {lr_sy[SYNC_N-2:0], lrclk_i};
            sd_sy   <= {sd_sy[SYNC_N-2:0], sdata_i};
        end
    end

    assign bclk_s    = bclk_sy[SYNC_N-1];
    assign lr_s      = lr_sy[SYNC_N-1];
    assign sd_s      = sd_sy[SYNC_N-1];
    assign bclk_rise = bclk_s & ~bclk_d;

    // Purpose: on each bit-clock rise, shift right-channel bits, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_d  <= 1'b0;
            lr_prev <= RIGHT_LVL;
            cnt     <= CNT_FULL;
            shreg   <= '0;
            done    <= 1'b0;
        end else begin
            bclk_d <= bclk_s;
            done   <= 1'b0;
            if (bclk_rise) begin
                lr_prev <= lr_s;
                if (lr_s == RIGHT_LVL) begin
                    if (lr_s != lr_prev) begin
                        shreg <= {{(W-1){1'b0}}, sd_s};
                        cnt   <= CW'(1);
                    end else if (cnt < CNT_FULL) begin
                        shreg <= {shreg[W-2:0], sd_s};
                        cnt   <= cnt + CW'(1);
                        if (cnt == CNT_LAST) done <= 1'b1;
                    end
                end
            end
        end
    end

    assign word_o     = shreg;
    assign word_vld_o = done;

    // R4: a finished word is announced for one cycle only
    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |=> !word_vld_o);
    // R4/R5: the bit counter never runs past the word width
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_FULL);
endmodule

// File: rtl/alm_gate.sv
// Module: alm_gate
// Dead-zone gate on the absolute value of a two's-complement word.
// Produces the gated word and its saturated magnitude. Purely combinational.
module alm_gate #(
    parameter int W          = alm_pkg::SAMPLE_W,
    parameter int GATE_LEVEL = 8
) (
    input  logic [W-1:0] word_i,
    output logic [W-1:0] gated_o,
    output logic [W-1:0] mag_o
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] LEVEL    = W'(GATE_LEVEL);

    logic [W-1:0] absval;

    // Purpose: absolute value, with the most negative code clamped.
    always_comb begin
        if (!word_i[W-1])           absval = word_i;
        else if (word_i == MOST_NEG) absval = MOST_POS;
        else                         absval = ~word_i + W'(1);
    end

    // Purpose: zero both outputs when the magnitude sits inside the dead zone.
    always_comb begin
        if (absval < LEVEL) begin
            gated_o = '0;
            mag_o   = '0;
        end else begin
            gated_o = word_i;
            mag_o   = absval;
        end
    end
endmodule

// File: rtl/alm_bar.sv
// Module: alm_bar
// Thermometer bar from an unsigned magnitude. Segment 0 lights for any
// nonzero value; segment k lights when the value is at least 2^(k-1).
// Assumes the segment count equals the magnitude width.
module alm_bar #(
    parameter int W = alm_pkg::SAMPLE_W
) (
    input  logic [W-1:0] mag_i,
    output logic [W-1:0] bar_o
);
    assign bar_o[0] = |mag_i;

    for (genvar k = 1; k < W; k++) begin : g_seg
        // Purpose: segment k lights when any bit at or above k-1 is set.
        assign bar_o[k] = |mag_i[W-1:k-1];
    end
endmodule

// File: rtl/audio_level_meter.sv
// Module: audio_level_meter
// Top level. Captures the right-channel word, gates idle noise and
// registers both the sample and its level bar with a one-cycle strobe.
// Assumes clk is at least 8x the bit clock and a frame-clock high level
// selects the right channel.
module audio_level_meter #(
    parameter int W          = alm_pkg::SAMPLE_W,
    parameter int GATE_LEVEL = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bclk_i,
    input  logic         lrclk_i,
    input  logic         sdata_i,
    output logic [W-1:0] sample_o,
    output logic [W-1:0] bar_o,
    output logic         sample_vld_o
);
    logic [W-1:0] rx_word, gated, mag, bar_next;
    logic         rx_vld;

    alm_serial_rx #(.W(W)) u_rx (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .lrclk_i(lrclk_i),
        .sdata_i(sdata_i), .word_o(rx_word), .word_vld_o(rx_vld)
    );

    alm_gate #(.W(W), .GATE_LEVEL(GATE_LEVEL)) u_gate (
        .word_i(rx_word), .gated_o(gated), .mag_o(mag)
    );

    alm_bar #(.W(W)) u_bar (.mag_i(mag), .bar_o(bar_next));

    // Purpose: register the gated sample and bar when a new word lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_o     <= '0;
            bar_o        <= '0;
            sample_vld_o <= 1'b0;
        end else begin
            sample_vld_o <= rx_vld;
            if (rx_vld) begin
                sample_o <= gated;
                bar_o    <= bar_next;
            end
        end
    end

    function automatic logic [W-1:0] chk_abs(input logic [W-1:0] v);
        if (!v[W-1]) return v;
        if (v == {1'b1, {(W-1){1'b0}}}) return {1'b0, {(W-1){1'b1}}};
        return ~v + W'(1);
    endfunction

    // R6: a sample that made it through has a magnitude at or above the level
    assert_gate_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_o != '0) |-> (chk_abs(sample_o) >= W'(GATE_LEVEL)));
    // R8: the bar is a contiguous run starting at segment 0
    assert_bar_contiguous_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((bar_o & (bar_o + W'(1))) == '0));
    // R8: an empty bar and a zero sample go together
    assert_bar_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((sample_o == '0) == (bar_o == '0)));
    // R9: outputs hold between strobes
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld_o |-> ($stable(sample_o) && $stable(bar_o)));
endmodule

// File: tb/tb_audio_level_meter.sv
`timescale 1ns/1ps
module tb_audio_level_meter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
    logic [15:0] sample, bar;
    logic        vld;
    int          checks = 0, errors = 0, vcount = 0, cyc = 0;

    always #2.5 clk = ~clk;

    audio_level_meter dut (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .lrclk_i(lrclk),
        .sdata_i(sdata), .sample_o(sample), .bar_o(bar), .sample_vld_o(vld)
    );

    // Strobe counter, sampled away from the active edge
    always @(negedge clk) if (rst_n && vld) vcount++;

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bit-clock period: data and frame clock change while bclk is low
    task automatic bit_out(input logic lr, input logic b);
        @(negedge clk);
        bclk = 1'b0; lrclk = lr; sdata = b;
        repeat (4) @(negedge clk);
        bclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // Left half of 16 bits, then nright right bits, then extra right ones
    task automatic send_frame(input logic [15:0] lw, input logic [15:0] rw,
                              input int nright, input int extra);
        for (int i = 15; i >= 0; i--) bit_out(1'b0, lw[i]);
        for (int i = 0; i < nright; i++) bit_out(1'b1, rw[15-i]);
        for (int i = 0; i < extra; i++) bit_out(1'b1, 1'b1);
        bit_out(1'b0, 1'b0);
        repeat (12) @(negedge clk);
    endtask

    // {input word, expected sample, expected bar}
    localparam logic [47:0] VEC [13] = '{
        {16'h0000, 16'h0000, 16'h0000},
        {16'h0006, 16'h0000, 16'h0000},
        {16'hFFFA, 16'h0000, 16'h0000},
        {16'h0007, 16'h0000, 16'h0000},
        {16'hFFF9, 16'h0000, 16'h0000},
        {16'h0008, 16'h0008, 16'h001F},
        {16'hFFF8, 16'hFFF8, 16'h001F},
        {16'h0064, 16'h0064, 16'h00FF},
        {16'hFC18, 16'hFC18, 16'h07FF},
        {16'h00FF, 16'h00FF, 16'h01FF},
        {16'h3FFF, 16'h3FFF, 16'h7FFF},
        {16'h4000, 16'h4000, 16'hFFFF},
        {16'h7FFF, 16'h7FFF, 16'hFFFF}
    };

    initial begin
        int v0;
        repeat (4) @(negedge clk);
        chk("R1 reset sample", sample, 16'h0000);
        chk("R1 reset bar", bar, 16'h0000);
        chk("R1 reset strobe", {15'd0, vld}, 16'h0000);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Vector table: capture (R2), gate (R6), bar (R8), one strobe (R4)
        for (int i = 0; i < 13; i++) begin
            v0 = vcount;
            send_frame(~VEC[i][47:32], VEC[i][47:32], 16, 0);
            chk("R2/R6 sample", sample, VEC[i][31:16]);
            chk("R8 bar", bar, VEC[i][15:0]);
            chk("R4 one strobe", 16'(vcount - v0), 16'd1);
        end

        // R7: most negative code saturates and fills the bar
        send_frame(16'h1234, 16'h8000, 16, 0);
        chk("R7 sample", sample, 16'h8000);
        chk("R7 bar", bar, 16'hFFFF);

        // R3: left-only frame leaves the outputs alone
        v0 = vcount;
        send_frame(16'h7FFF, 16'h0000, 0, 0);
        chk("R3 sample", sample, 16'h8000);
        chk("R3 bar", bar, 16'hFFFF);
        chk("R3 no strobe", 16'(vcount - v0), 16'd0);

        // R4: truncated right half produces nothing
        v0 = vcount;
        send_frame(16'h0000, 16'h0100, 10, 0);
        chk("R4 short sample", sample, 16'h8000);
        chk("R4 short strobe", 16'(vcount - v0), 16'd0);

        // R5: extra bits after the 16th are dropped
        v0 = vcount;
        send_frame(16'hFFFF, 16'h0100, 16, 5);
        chk("R5 sample", sample, 16'h0100);
        chk("R5 bar", bar, 16'h03FF);
        chk("R5 one strobe", 16'(vcount - v0), 16'd1);

        // R9: idle interval keeps outputs steady
        repeat (50) @(negedge clk);
        chk("R9 hold sample", sample, 16'h0100);
        chk("R9 hold bar", bar, 16'h03FF);

        // R1: reset in operation clears outputs
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 rereset sample", sample, 16'h0000);
        chk("R1 rereset bar", bar, 16'h0000);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule